// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel flash write bus and turns multi-write command sequences into operating modes and one-cycle operation strobes. Each bus write carries an 18-bit word address and a 16-bit value. Most commands need a two-write unlock prefix. Erase needs the prefix a second time. A bypass mode cuts programming down to two writes.

The block holds the current operating mode: array read, autoselect, unlock bypass, erase suspended or busy. When a sequence completes it raises one strobe for program, chip erase, sector erase, suspend or resume. The target address and value, or the sector number, are latched alongside the strobe. The array itself and the embedded timing are outside the block. An `op_done` pulse from that logic ends the busy period. In autoselect mode a combinational read port returns the manufacturer code and the per-sector protection flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `mode_o` is 0 (array read) and all five strobes are low. The mode codes are 0 read, 1 autoselect, 2 unlock bypass, 3 erase suspended and 4 busy.
- R2: The unlock prefix is value 0xAA at address 0x555 and then 0x55 at 0x2AA when `byte_mode`=0. When `byte_mode`=1 the addresses are 0xAAA and 0x555, and the command address becomes 0xAAA. Data bits 15..8 are ignored on these cycles. Address bits above bit 10 are ignored when `byte_mode`=0, and bits above bit 11 when `byte_mode`=1.
- R3: Unlock, then 0xA0 at the command address, then a fourth write raises `pgm_stb` for exactly one cycle, one clock after that write. `pgm_addr` and `pgm_data` hold that write's address and full value, and the mode becomes 4. At most one strobe is high in any cycle.
- R4: A write that does not match the expected value or address at any step abandons the partial sequence. No strobe fires and the mode is unchanged.
- R5: Unlock, then 0x90 at the command address, enters autoselect (mode 1). Only a write of 0xF0 leaves autoselect, and it returns to the mode autoselect was entered from. A 0xF0 written in array-read mode has no effect.
- R6: In autoselect, `id_data` is 0x37 when the in-sector offset is 0. At offset 2 it is 1 if the bit of `sector_prot` indexed by `rd_addr[17:12]` is set, and 0 otherwise. Any other offset reads 0, and `id_data` is 0 outside autoselect. The offset is `rd_addr[10:0]` when `byte_mode`=0 and `rd_addr[11:1]` when `byte_mode`=1.
- R7: Unlock, then 0x20 at the command address, enters unlock bypass (mode 2). In bypass, 0xA0 at any address followed by a data write raises `pgm_stb`, and `op_done` returns the mode to 2.
- R8: Unlock bypass is left only by 0x90 at any address followed by 0x00 at any address. A 0xF0 write, or 0x90 followed by some other value, leaves the mode at 2.
- R9: Unlock, 0x80 at the command address, then unlock again, then a sixth write: 0x10 at the command address raises `chip_erase_stb`; 0x30 at any address raises `sect_erase_stb` with `sector` = address bits 17..12. Either one sets mode 4.
- R10: In mode 4 every write is ignored except the suspend command during an erase. An `op_done` pulse returns the mode to the one the operation was launched from.
- R11: 0xB0 written while an erase is busy raises `suspend_stb` and sets mode 3. 0x30 written in mode 3 raises `resume_stb` and sets mode 4. Neither command has any effect in other modes.
- R12: In mode 3 a full program sequence is accepted, and `op_done` then returns the mode to 3. An erase sequence is refused. Autoselect entered from mode 3 returns to mode 3 on 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses and autoselect offsets |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 18 | Write address |
| wr_data | input | 16 | Write value |
| op_done | input | 1 | Pulse from the embedded operation logic: operation finished |
| rd_addr | input | 18 | Autoselect read address |
| sector_prot | input | 64 | Protection flag per sector |
| mode_o | output | 3 | Operating mode code |
| pgm_stb | output | 1 | Program request strobe |
| pgm_addr | output | 18 | Latched program address |
| pgm_data | output | 16 | Latched program value |
| chip_erase_stb | output | 1 | Chip erase request strobe |
| sect_erase_stb | output | 1 | Sector erase request strobe |
| sector | output | 6 | Latched sector number for sector erase |
| suspend_stb | output | 1 | Erase suspend strobe |
| resume_stb | output | 1 | Erase resume strobe |
| id_data | output | 8 | Autoselect read value |

## Verification
The bench drives unlock writes with the ignored data and address bits set. A decoder that compares the full bus would then miss every sequence. Broken sequences, and writes made while busy, are checked for silence: a design that kept partial progress or accepted writes while busy would raise a stray program strobe. Bypass is exercised with 0xF0, with an incomplete exit pair and with the full exit pair, which catches a design that leaves bypass too easily. The suspend path covers several cases: programming while suspended, a suspend command issued during that program, resume, and the mode restored after each `op_done`. A design with a single return mode would land in the wrong place.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
    localparam int CMD_W = 8;

    typedef enum logic [2:0] {
        MODE_READ   = 3'd0,
        MODE_AUTO   = 3'd1,
        MODE_BYPASS = 3'd2,
        MODE_SUSP   = 3'd3,
        MODE_BUSY   = 3'd4
    } fc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_UNL1 = 3'd1,
        ST_UNL2 = 3'd2,
        ST_PGM  = 3'd3,
        ST_ER3  = 3'd4,
        ST_ER4  = 3'd5,
        ST_ER5  = 3'd6,
        ST_BYX  = 3'd7
    } fc_step_e;

    localparam logic [CMD_W-1:0] C_UNL_A  = 8'hAA;
    localparam logic [CMD_W-1:0] C_UNL_B  = 8'h55;
    localparam logic [CMD_W-1:0] C_RESET  = 8'hF0;
    localparam logic [CMD_W-1:0] C_AUTO   = 8'h90;
    localparam logic [CMD_W-1:0] C_PGM    = 8'hA0;
    localparam logic [CMD_W-1:0] C_BYPASS = 8'h20;
    localparam logic [CMD_W-1:0] C_ERASE  = 8'h80;
    localparam logic [CMD_W-1:0] C_CHIP   = 8'h10;
    localparam logic [CMD_W-1:0] C_SECT   = 8'h30;
    localparam logic [CMD_W-1:0] C_SUSP   = 8'hB0;
    localparam logic [CMD_W-1:0] C_BYXIT  = 8'h00;
    localparam logic [CMD_W-1:0] C_MFR_ID = 8'h37;
endpackage

// File: rtl/flash_cmd_addr_cmp.sv
`timescale 1ns/1ps
module flash_cmd_addr_cmp #(
    parameter int ADDR_W = 18
) (
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_a,
    output logic              hit_b
);
    localparam int WCMP_W = 11;
    localparam int BCMP_W = 12;
    localparam logic [WCMP_W-1:0] W_A = 11'h555;
    localparam logic [WCMP_W-1:0] W_B = 11'h2AA;
    localparam logic [BCMP_W-1:0] B_A = 12'hAAA;
    localparam logic [BCMP_W-1:0] B_B = 12'h555;

    always_comb begin
        if (byte_mode) begin
            hit_a = (addr[BCMP_W-1:0] == B_A);
            hit_b = (addr[BCMP_W-1:0] == B_B);
        end else begin
            hit_a = (addr[WCMP_W-1:0] == W_A);
            hit_b = (addr[WCMP_W-1:0] == W_B);
        end
    end
endmodule

// File: rtl/flash_cmd_id_read.sv
`timescale 1ns/1ps
module flash_cmd_id_read
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 6
) (
    input  fc_mode_e             mode,
    input  logic                 byte_mode,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [(1<<SECT_W)-1:0] sector_prot,
    output logic [CMD_W-1:0]     id_data
);
    localparam int OFF_W = 11;
    logic [OFF_W-1:0]  off;
    logic [SECT_W-1:0] sidx;

    always_comb begin
        off  = byte_mode ? rd_addr[OFF_W:1] : rd_addr[OFF_W-1:0];
        sidx = rd_addr[ADDR_W-1 -: SECT_W];
        id_data = '0;
        if (mode == MODE_AUTO) begin
            if (off == OFF_W'(0))      id_data = C_MFR_ID;
            else if (off == OFF_W'(2)) id_data = {{(CMD_W-1){1'b0}}, sector_prot[sidx]};
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int SECT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic              op_done,
    output fc_mode_e          mode,
    output logic              pgm_stb,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              chip_stb,
    output logic              sect_stb,
    output logic [SECT_W-1:0] sector,
    output logic              susp_stb,
    output logic              res_stb
);
    typedef struct packed {
        fc_mode_e          mode;
        fc_step_e          step;
        fc_mode_e          auto_base;
        fc_mode_e          busy_ret;
        logic              erase_run;
        logic              pgm_stb;
        logic              chip_stb;
        logic              sect_stb;
        logic              susp_stb;
        logic              res_stb;
        logic [ADDR_W-1:0] pgm_addr;
        logic [DATA_W-1:0] pgm_data;
        logic [SECT_W-1:0] sector;
    } st_t;

    st_t st_d, st_q;
    logic [CMD_W-1:0] cmd;

    always_comb begin
        st_d          = st_q;
        st_d.pgm_stb  = 1'b0;
        st_d.chip_stb = 1'b0;
        st_d.sect_stb = 1'b0;
        st_d.susp_stb = 1'b0;
        st_d.res_stb  = 1'b0;
        cmd           = wr_data[CMD_W-1:0];

        if (st_q.mode == MODE_BUSY && op_done) begin
            st_d.mode = st_q.busy_ret;
            st_d.step = ST_IDLE;
        end else if (wr_en) begin
            case (st_q.mode)
                MODE_BUSY: begin
                    if (st_q.erase_run && cmd == C_SUSP) begin
                        st_d.mode     = MODE_SUSP;
                        st_d.susp_stb = 1'b1;
                    end
                end
                MODE_AUTO: begin
                    if (cmd == C_RESET) st_d.mode = st_q.auto_base;
                end
                MODE_BYPASS: begin
                    st_d.step = ST_IDLE;
                    case (st_q.step)
                        ST_IDLE: begin
                            if (cmd == C_PGM)       st_d.step = ST_PGM;
                            else if (cmd == C_AUTO) st_d.step = ST_BYX;
                        end
                        ST_PGM: begin
                            st_d.pgm_stb   = 1'b1;
                            st_d.pgm_addr  = wr_addr;
                            st_d.pgm_data  = wr_data;
                            st_d.busy_ret  = MODE_BYPASS;
                            st_d.erase_run = 1'b0;
                            st_d.mode      = MODE_BUSY;
                        end
                        ST_BYX: begin
                            if (cmd == C_BYXIT) st_d.mode = MODE_READ;
                        end
                        default: ;
                    endcase
                end
                default: begin
                    // array read or erase suspended
                    st_d.step = ST_IDLE;
                    case (st_q.step)
                        ST_IDLE: begin
                            if (cmd == C_UNL_A && hit_a) begin
                                st_d.step = ST_UNL1;
                            end else if (st_q.mode == MODE_SUSP && cmd == C_SECT) begin
                                st_d.res_stb   = 1'b1;
                                st_d.mode      = MODE_BUSY;
                                st_d.erase_run = 1'b1;
                                st_d.busy_ret  = MODE_READ;
                            end
                        end
                        ST_UNL1: if (cmd == C_UNL_B && hit_b) st_d.step = ST_UNL2;
                        ST_UNL2: begin
                            if (hit_a) begin
                                if (cmd == C_AUTO) begin
                                    st_d.mode      = MODE_AUTO;
                                    st_d.auto_base = st_q.mode;
                                end else if (cmd == C_PGM) begin
                                    st_d.step = ST_PGM;
                                end else if (cmd == C_BYPASS && st_q.mode == MODE_READ) begin
                                    st_d.mode = MODE_BYPASS;
                                end else if (cmd == C_ERASE && st_q.mode == MODE_READ) begin
                                    st_d.step = ST_ER3;
                                end
                            end
                        end
                        ST_PGM: begin
                            st_d.pgm_stb   = 1'b1;
                            st_d.pgm_addr  = wr_addr;
                            st_d.pgm_data  = wr_data;
                            st_d.busy_ret  = st_q.mode;
                            st_d.erase_run = 1'b0;
                            st_d.mode      = MODE_BUSY;
                        end
                        ST_ER3: if (cmd == C_UNL_A && hit_a) st_d.step = ST_ER4;
                        ST_ER4: if (cmd == C_UNL_B && hit_b) st_d.step = ST_ER5;
                        ST_ER5: begin
                            if (cmd == C_CHIP && hit_a) begin
                                st_d.chip_stb  = 1'b1;
                                st_d.mode      = MODE_BUSY;
                                st_d.erase_run = 1'b1;
                                st_d.busy_ret  = MODE_READ;
                            end else if (cmd == C_SECT) begin
                                st_d.sect_stb  = 1'b1;
                                st_d.sector    = wr_addr[ADDR_W-1 -: SECT_W];
                                st_d.mode      = MODE_BUSY;
                                st_d.erase_run = 1'b1;
                                st_d.busy_ret  = MODE_READ;
                            end
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mode      <= MODE_READ;
            st_q.step      <= ST_IDLE;
            st_q.auto_base <= MODE_READ;
            st_q.busy_ret  <= MODE_READ;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.mode;
    assign pgm_stb  = st_q.pgm_stb;
    assign pgm_addr = st_q.pgm_addr;
    assign pgm_data = st_q.pgm_data;
    assign chip_stb = st_q.chip_stb;
    assign sect_stb = st_q.sect_stb;
    assign sector   = st_q.sector;
    assign susp_stb = st_q.susp_stb;
    assign res_stb  = st_q.res_stb;
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int SECT_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_mode,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   op_done,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [(1<<SECT_W)-1:0] sector_prot,
    output logic [2:0]             mode_o,
    output logic                   pgm_stb,
    output logic [ADDR_W-1:0]      pgm_addr,
    output logic [DATA_W-1:0]      pgm_data,
    output logic                   chip_erase_stb,
    output logic                   sect_erase_stb,
    output logic [SECT_W-1:0]      sector,
    output logic                   suspend_stb,
    output logic                   resume_stb,
    output logic [CMD_W-1:0]       id_data
);
    logic     hit_a, hit_b;
    fc_mode_e mode;

    flash_cmd_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .byte_mode (byte_mode),
        .addr      (wr_addr),
        .hit_a     (hit_a),
        .hit_b     (hit_b)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .op_done  (op_done),
        .mode     (mode),
        .pgm_stb  (pgm_stb),
        .pgm_addr (pgm_addr),
        .pgm_data (pgm_data),
        .chip_stb (chip_erase_stb),
        .sect_stb (sect_erase_stb),
        .sector   (sector),
        .susp_stb (suspend_stb),
        .res_stb  (resume_stb)
    );

    flash_cmd_id_read #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_id (
        .mode        (mode),
        .byte_mode   (byte_mode),
        .rd_addr     (rd_addr),
        .sector_prot (sector_prot),
        .id_data     (id_data)
    );

    assign mode_o = mode;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
`timescale 1ns/1ps
module flash_cmd_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_done,
    input logic [2:0]        mode_o,
    input logic              pgm_stb,
    input logic              chip_erase_stb,
    input logic              sect_erase_stb,
    input logic              suspend_stb,
    input logic              resume_stb
);
    assert_stb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb}));

    assert_pgm_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_stb |-> $past(wr_en));

    assert_auto_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && !(wr_en && wr_data[7:0] == 8'hF0)) |=> mode_o == 3'd1);

    assert_bypass_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && !wr_en) |=> mode_o == 3'd2);

    assert_erase_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_erase_stb || sect_erase_stb) |-> mode_o == 3'd4);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && !wr_en && !op_done) |=> mode_o == 3'd4);

    assert_done_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && op_done) |=> mode_o != 3'd4);

    assert_susp_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_stb |-> $past(mode_o) == 3'd4);

    assert_resume_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |-> $past(mode_o) == 3'd3);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .op_done        (op_done),
    .mode_o         (mode_o),
    .pgm_stb        (pgm_stb),
    .chip_erase_stb (chip_erase_stb),
    .sect_erase_stb (sect_erase_stb),
    .suspend_stb    (suspend_stb),
    .resume_stb     (resume_stb)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic [17:0] rd_addr = '0;
    logic [63:0] sector_prot = 64'h20;
    logic [2:0]  mode_o;
    logic        pgm_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb;
    logic [17:0] pgm_addr;
    logic [15:0] pgm_data;
    logic [5:0]  sector;
    logic [7:0]  id_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [4:0] cap; // {pgm, chip, sect, susp, res} seen on last write

    always #2.5 clk = ~clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .op_done(op_done),
        .rd_addr(rd_addr), .sector_prot(sector_prot), .mode_o(mode_o),
        .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .chip_erase_stb(chip_erase_stb), .sect_erase_stb(sect_erase_stb),
        .sector(sector), .suspend_stb(suspend_stb), .resume_stb(resume_stb),
        .id_data(id_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        cap = {pgm_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb};
        wr_en = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    function automatic logic [17:0] a1(); return byte_mode ? 18'hAAA : 18'h555; endfunction
    function automatic logic [17:0] a2(); return byte_mode ? 18'h555 : 18'h2AA; endfunction

    task automatic unlock();
        wr(a1(), 16'h00AA);
        wr(a2(), 16'h0055);
    endtask

    task automatic t_reset();
        check("R1 mode after reset", mode_o, 0);
        check("R1 strobes after reset",
              {pgm_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb}, 0);
    endtask

    task automatic t_program_word();
        unlock();
        wr(a1(), 16'h00A0);
        check("R3 no strobe before data", cap, 0);
        wr(18'h31234, 16'hBEEF);
        check("R3 pgm strobe", cap, 5'b10000);
        check("R3 pgm addr", pgm_addr, 18'h31234);
        check("R3 pgm data", pgm_data, 16'hBEEF);
        check("R3 mode busy", mode_o, 4);
        @(negedge clk);
        check("R3 strobe one cycle", pgm_stb, 0);
        done_pulse();
        check("R10 done to read", mode_o, 0);
    endtask

    task automatic t_ignored_bits();
        wr(18'h3FD55, 16'hFFAA);
        wr(18'h3FAAA, 16'h1255);
        wr(18'h20D55, 16'h77A0);
        wr(18'h00042, 16'h5A5A);
        check("R2 upper bits ignored pgm", cap, 5'b10000);
        check("R2 data latched", pgm_data, 16'h5A5A);
        done_pulse();
    endtask

    task automatic t_byte_mode();
        byte_mode = 1'b1;
        wr(18'h555, 16'h00AA);  // word address is wrong in byte mode
        wr(18'h2AA, 16'h0055);
        wr(18'h555, 16'h00A0);
        wr(18'h00100, 16'h1111);
        check("R2 word addrs refused in byte mode", cap, 0);
        unlock();
        wr(a1(), 16'h00A0);
        wr(18'h00100, 16'h2222);
        check("R2 byte-mode pgm", cap, 5'b10000);
        done_pulse();
        byte_mode = 1'b0;
    endtask

    task automatic t_abort();
        unlock();
        wr(18'h555, 16'h0077);
        wr(18'h555, 16'h00A0);
        wr(18'h00010, 16'h3333);
        check("R4 bad third write no pgm", cap, 0);
        check("R4 mode unchanged", mode_o, 0);
        wr(18'h555, 16'h00AA);
        wr(18'h2AB, 16'h0055);
        wr(18'h555, 16'h00A0);
        wr(18'h00010, 16'h3333);
        check("R4 bad unlock address no pgm", cap, 0);
    endtask

    task automatic t_autoselect();
        wr(18'h00000, 16'h00F0);
        check("R5 reset in read harmless", mode_o, 0);
        rd_addr = 18'h0;
        @(negedge clk);
        check("R6 id zero outside autoselect", id_data, 0);
        unlock();
        wr(18'h555, 16'h0090);
        check("R5 autoselect entered", mode_o, 1);
        rd_addr = 18'h00000; @(negedge clk);
        check("R6 manufacturer code", id_data, 8'h37);
        rd_addr = {6'd5, 12'h002}; @(negedge clk);
        check("R6 protected sector", id_data, 8'h01);
        rd_addr = {6'd6, 12'h002}; @(negedge clk);
        check("R6 unprotected sector", id_data, 8'h00);
        unlock();
        wr(18'h555, 16'h00A0);
        wr(18'h00001, 16'h4444);
        check("R5 pgm ignored in autoselect", cap, 0);
        check("R5 still autoselect", mode_o, 1);
        wr(18'h12345, 16'hABF0);
        check("R5 F0 leaves autoselect", mode_o, 0);
    endtask

    task automatic t_bypass();
        unlock();
        wr(18'h555, 16'h0020);
        check("R7 bypass entered", mode_o, 2);
        wr(18'h12345, 16'h00A0);
        wr(18'h0ABCD, 16'hC0DE);
        check("R7 bypass pgm strobe", cap, 5'b10000);
        check("R7 bypass pgm addr", pgm_addr, 18'h0ABCD);
        done_pulse();
        check("R7 back to bypass after done", mode_o, 2);
        wr(18'h00000, 16'h00F0);
        check("R8 F0 ignored in bypass", mode_o, 2);
        wr(18'h00000, 16'h0090);
        wr(18'h00000, 16'h0055);
        check("R8 incomplete exit stays", mode_o, 2);
        wr(18'h01234, 16'h0090);
        wr(18'h04321, 16'h0000);
        check("R8 exit to read", mode_o, 0);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(a1(), 16'h0080);
        unlock();
    endtask

    task automatic t_chip_erase();
        wr(18'h00000, 16'h00B0);
        check("R11 suspend ignored in read", cap, 0);
        wr(18'h00000, 16'h0030);
        check("R11 resume ignored in read", cap, 0);
        erase_prefix();
        wr(18'h555, 16'h0010);
        check("R9 chip erase strobe", cap, 5'b01000);
        check("R9 chip erase busy", mode_o, 4);
        unlock();
        wr(18'h555, 16'h00A0);
        wr(18'h00002, 16'h9999);
        check("R10 writes ignored while busy", cap, 0);
        done_pulse();
        check("R10 done after erase", mode_o, 0);
    endtask

    task automatic t_sector_suspend();
        erase_prefix();
        wr(18'h2B777, 16'h0030);
        check("R9 sector erase strobe", cap, 5'b00100);
        check("R9 sector number", sector, 6'h2B);
        wr(18'h00000, 16'h00B0);
        check("R11 suspend strobe", cap, 5'b00010);
        check("R11 suspended mode", mode_o, 3);
        erase_prefix();
        wr(18'h555, 16'h0010);
        check("R12 erase refused when suspended", cap, 0);
        check("R12 still suspended", mode_o, 3);
        unlock();
        wr(18'h555, 16'h00A0);
        wr(18'h01000, 16'h0F0F);
        check("R12 pgm in suspend", cap, 5'b10000);
        wr(18'h00000, 16'h00B0);
        check("R11 no suspend during program", cap, 0);
        done_pulse();
        check("R12 done back to suspend", mode_o, 3);
        unlock();
        wr(18'h555, 16'h0090);
        check("R12 autoselect from suspend", mode_o, 1);
        wr(18'h00000, 16'h00F0);
        check("R12 F0 back to suspend", mode_o, 3);
        wr(18'h3FFFF, 16'h0030);
        check("R11 resume strobe", cap, 5'b00001);
        check("R11 resumed busy", mode_o, 4);
        done_pulse();
        check("R10 done after resumed erase", mode_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_program_word();
        t_ignored_bits();
        t_byte_mode();
        t_abort();
        t_autoselect();
        t_bypass();
        t_chip_erase();
        t_sector_suspend();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule